// File: doc/BRIEF.md
# Elliptic Curve Point Step Engine

This block offloads the inner step of an elliptic curve point walk over a 109-bit prime field. A host loads three operands (the x and y coordinates of the current point and a precomputed modular inverse), chooses one of three fixed step programs with a 2-bit selector, and pulses `start`. Two of the programs add the current point to one of two fixed base points. The third doubles the current point using the curve coefficient.

Each program is a hard-wired list of modular add, subtract and multiply steps. The steps run one after another on a small set of temporaries: a slope, three scratch values and the result. The engine has no inversion unit. The host supplies the inverse, and the engine scales the slope by it. Only the new y coordinate is returned.

The datapath holds one single-cycle modular add/subtract unit and one bit-serial modular multiplier. Both reduce every value into the range [0, P) before it is stored. The curve constants and the modulus are fixed values inside the block.

Top module: `ec_step_engine`

## Requirements
- R1: Every stored value and the `result` output lie in [0, P), where P = 0x1BD579792B380B5B521E6D9FB599. This holds for operands of 0 and P−1.
- R2: `path_sel`=0 (add base point G1, with G1x = 0x04CC974EBBCBFDC3636FEB9F11C7 and G1y = 0x07611B0EB1229C0BFC5F35521692) returns the value computed by this program, with every operation taken mod P:
  - s = (G1y − y)·inv
  - u = x + G1x
  - v = s² − u
  - result = s·(x − v) − y
- R3: `path_sel`=1 runs the same program as R2 with G2x = 0x0233857E4E8B5F0055126E7D7B7C and G2y = 0x19C8C91063EB4276371D68B6B4D9.
- R4: `path_sel`=2 (doubling, with coefficient K = 0x0FD4C926FD178E9805E663021744) returns the value computed by this program, with every operation taken mod P:
  - q = x²
  - s = (q + q + q + K)·inv
  - v = s² − x − x
  - result = s·(x − v) − y
- R5: `path_sel`=3 is invalid. `done` rises in the first cycle after the start edge, with `err`=1 and `result`=0.
- R6: A `start` pulse is accepted only when `busy` is low. A start while busy has no effect on the running program, on its result or on its timing.
- R7: Each multiply step takes 111 cycles and each add or subtract step takes 1 cycle. Count L as the sum of the step times: L = 338 for `path_sel` 0 and 1, and L = 451 for `path_sel` 2. Counting cycle 1 as the cycle after the accepting edge:
  - `busy` is high in cycles 1 to L+1.
  - `done` is high only in cycle L+1, as a one-cycle pulse.
  - `busy` is low from cycle L+2 on.
- R8: An accepted start clears `result` to 0 and sets `err` to the invalid-selector flag. Both then hold their final values until the next accepted start.
- R9: After reset, `busy`, `done`, `err` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a program; accepted only while idle |
| path_sel | input | 2 | 0: add G1, 1: add G2, 2: double, 3: invalid |
| x_in | input | 109 | Current x coordinate, reduced |
| y_in | input | 109 | Current y coordinate, reduced |
| inv_in | input | 109 | Host-supplied inverse that scales the slope |
| busy | output | 1 | High from acceptance up to and including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Invalid selector flag for the last accepted start |
| result | output | 109 | New y coordinate |

## Verification
The hardest case to reach from the ports is a start pulse that arrives while a multiply is in progress deep inside a program. It must not reload the operands, restart the program or shift the done cycle. The stimulus raises `start` with a different selector and new operands for several cycles in the middle of a run. It then checks that the program still ends in cycle L+1 with the result of the original operands. Reduction corner cases are reached by feeding all-zero and all-(P−1) operands, so the additions and squarings land near the modulus boundary.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  localparam int FW = 109;
  typedef logic [FW-1:0] fe_t;

  localparam logic [111:0] MOD_W  = 112'h1BD579792B380B5B521E6D9FB599;
  localparam logic [111:0] G1X_W  = 112'h04CC974EBBCBFDC3636FEB9F11C7;
  localparam logic [111:0] G1Y_W  = 112'h07611B0EB1229C0BFC5F35521692;
  localparam logic [111:0] G2X_W  = 112'h0233857E4E8B5F0055126E7D7B7C;
  localparam logic [111:0] G2Y_W  = 112'h19C8C91063EB4276371D68B6B4D9;
  localparam logic [111:0] COEF_W = 112'h0FD4C926FD178E9805E663021744;

  localparam fe_t MOD  = MOD_W[FW-1:0];
  localparam fe_t G1X  = G1X_W[FW-1:0];
  localparam fe_t G1Y  = G1Y_W[FW-1:0];
  localparam fe_t G2X  = G2X_W[FW-1:0];
  localparam fe_t G2Y  = G2Y_W[FW-1:0];
  localparam fe_t COEF = COEF_W[FW-1:0];

  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_MUL} op_e;
  typedef enum logic [3:0] {S_X, S_Y, S_INV, S_SLP, S_T, S_T2, S_TX, S_CX, S_CY, S_CK} src_e;
  typedef enum logic [2:0] {D_SLP, D_T, D_T2, D_TX, D_RES} dst_e;

  typedef struct packed {
    op_e  op;
    src_e a;
    src_e b;
    dst_e d;
    logic last;
  } step_t;

  function automatic fe_t mod_add(fe_t a, fe_t b);
    logic [FW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, MOD}) s = s - {1'b0, MOD};
    return s[FW-1:0];
  endfunction

  function automatic fe_t mod_sub(fe_t a, fe_t b);
    logic [FW:0] d;
    d = {1'b0, a} - {1'b0, b};
    if (d[FW]) d = d + {1'b0, MOD};
    return d[FW-1:0];
  endfunction

  // one MSB-first interleaved step: 2*acc (+a), then at most two corrections
  function automatic fe_t mul_iter(fe_t acc, fe_t a, logic bit_i);
    logic [FW+1:0] v;
    v = {1'b0, acc, 1'b0} + (bit_i ? {2'b00, a} : '0);
    if (v >= {2'b00, MOD}) v = v - {2'b00, MOD};
    if (v >= {2'b00, MOD}) v = v - {2'b00, MOD};
    return v[FW-1:0];
  endfunction

  function automatic step_t ucode(logic [1:0] path, logic [3:0] idx);
    step_t s;
    s = '{OP_ADD, S_X, S_X, D_RES, 1'b1};
    if (path == 2'd2) begin
      case (idx)
        4'd0:  s = '{OP_MUL, S_X,   S_X,   D_T,   1'b0};
        4'd1:  s = '{OP_ADD, S_T,   S_T,   D_T2,  1'b0};
        4'd2:  s = '{OP_ADD, S_T2,  S_T,   D_T2,  1'b0};
        4'd3:  s = '{OP_ADD, S_T2,  S_CK,  D_SLP, 1'b0};
        4'd4:  s = '{OP_MUL, S_SLP, S_INV, D_SLP, 1'b0};
        4'd5:  s = '{OP_MUL, S_SLP, S_SLP, D_T,   1'b0};
        4'd6:  s = '{OP_SUB, S_T,   S_X,   D_T,   1'b0};
        4'd7:  s = '{OP_SUB, S_T,   S_X,   D_TX,  1'b0};
        4'd8:  s = '{OP_SUB, S_X,   S_TX,  D_T,   1'b0};
        4'd9:  s = '{OP_MUL, S_SLP, S_T,   D_T,   1'b0};
        default: s = '{OP_SUB, S_T, S_Y,   D_RES, 1'b1};
      endcase
    end else begin
      case (idx)
        4'd0:  s = '{OP_SUB, S_CY,  S_Y,   D_SLP, 1'b0};
        4'd1:  s = '{OP_MUL, S_SLP, S_INV, D_SLP, 1'b0};
        4'd2:  s = '{OP_ADD, S_X,   S_CX,  D_T,   1'b0};
        4'd3:  s = '{OP_MUL, S_SLP, S_SLP, D_T2,  1'b0};
        4'd4:  s = '{OP_SUB, S_T2,  S_T,   D_TX,  1'b0};
        4'd5:  s = '{OP_SUB, S_X,   S_TX,  D_T,   1'b0};
        4'd6:  s = '{OP_MUL, S_SLP, S_T,   D_T,   1'b0};
        default: s = '{OP_SUB, S_T, S_Y,   D_RES, 1'b1};
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/ecs_addsub.sv
module ecs_addsub
  import ecs_pkg::*;
(
  input  fe_t  a,
  input  fe_t  b,
  input  logic sub,
  output fe_t  y
);
  assign y = sub ? mod_sub(a, b) : mod_add(a, b);
endmodule

// File: rtl/ecs_mulser.sv
module ecs_mulser
  import ecs_pkg::*;
#(
  parameter int W = FW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  fe_t  a,
  input  fe_t  b,
  output logic done,
  output fe_t  prod
);
  localparam int CW = $clog2(W + 1);

  fe_t          ma, mb, acc;
  logic [CW-1:0] cnt;
  logic          run;
  logic          last_iter;

  assign last_iter = run && (cnt == CW'(1));
  assign prod      = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma <= '0; mb <= '0; acc <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        ma  <= a;
        mb  <= b;
        acc <= '0;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        acc <= mul_iter(acc, ma, mb[W-1]);
        mb  <= {mb[W-2:0], 1'b0};
        cnt <= cnt - CW'(1);
        if (last_iter) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r1_mul_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod < MOD));
  a_r7_mul_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last_iter |=> (done && !run));
endmodule

// File: rtl/ec_step_engine.sv
module ec_step_engine
  import ecs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     path_sel,
  input  logic [FW-1:0]  x_in,
  input  logic [FW-1:0]  y_in,
  input  logic [FW-1:0]  inv_in,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [FW-1:0]  result
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_FIN} state_e;

  state_e     state;
  logic [1:0] path_r;
  logic [3:0] idx;
  fe_t        x_r, y_r, inv_r, slp, t, t2, tx, res;
  logic       err_r;

  step_t step;
  fe_t   opa, opb, cx, cy, as_out, mul_prod, wr_data;
  logic  mul_go, mul_done, wr_en, accept;

  assign step   = ucode(path_r, idx);
  assign cx     = (path_r == 2'd1) ? G2X : G1X;
  assign cy     = (path_r == 2'd1) ? G2Y : G1Y;
  assign accept = (state == ST_IDLE) && start;
  assign mul_go = (state == ST_RUN) && (step.op == OP_MUL);
  assign wr_en  = ((state == ST_RUN) && (step.op != OP_MUL)) ||
                  ((state == ST_WAIT) && mul_done);
  assign wr_data = (state == ST_WAIT) ? mul_prod : as_out;

  function automatic fe_t pick(src_e s, fe_t vx, fe_t vy, fe_t vi, fe_t vs,
                               fe_t vt, fe_t vt2, fe_t vtx, fe_t vcx, fe_t vcy);
    case (s)
      S_X:   return vx;
      S_Y:   return vy;
      S_INV: return vi;
      S_SLP: return vs;
      S_T:   return vt;
      S_T2:  return vt2;
      S_TX:  return vtx;
      S_CX:  return vcx;
      S_CY:  return vcy;
      default: return COEF;
    endcase
  endfunction

  assign opa = pick(step.a, x_r, y_r, inv_r, slp, t, t2, tx, cx, cy);
  assign opb = pick(step.b, x_r, y_r, inv_r, slp, t, t2, tx, cx, cy);

  ecs_addsub u_as (
    .a(opa), .b(opb), .sub(step.op == OP_SUB), .y(as_out)
  );

  ecs_mulser #(.W(FW)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go), .a(opa), .b(opb),
    .done(mul_done), .prod(mul_prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; path_r <= '0; idx <= '0; err_r <= 1'b0;
      x_r <= '0; y_r <= '0; inv_r <= '0;
      slp <= '0; t <= '0; t2 <= '0; tx <= '0; res <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          path_r <= path_sel;
          x_r    <= x_in;
          y_r    <= y_in;
          inv_r  <= inv_in;
          res    <= '0;
          idx    <= '0;
          err_r  <= (path_sel == 2'd3);
          state  <= (path_sel == 2'd3) ? ST_FIN : ST_RUN;
        end
        ST_RUN:  if (step.op == OP_MUL) state <= ST_WAIT;
        ST_WAIT: if (mul_done) state <= ST_RUN;
        default: state <= ST_IDLE;
      endcase
      if (wr_en) begin
        case (step.d)
          D_SLP:   slp <= wr_data;
          D_T:     t   <= wr_data;
          D_T2:    t2  <= wr_data;
          D_TX:    tx  <= wr_data;
          default: res <= wr_data;
        endcase
        if (step.last) state <= ST_FIN;
        else           idx   <= idx + 4'd1;
      end
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);
  assign err    = err_r;
  assign result = res;

  a_r1_write_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data < MOD));
  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0));
  a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(x_r) && $stable(y_r) && $stable(inv_r) && $stable(path_r));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(err)));
endmodule

// File: tb/ec_step_engine_test.sv
module ec_step_engine_test;
  localparam logic [127:0] PM = 128'h00001BD579792B380B5B521E6D9FB599;
  localparam logic [127:0] AX = 128'h000004CC974EBBCBFDC3636FEB9F11C7;
  localparam logic [127:0] AY = 128'h000007611B0EB1229C0BFC5F35521692;
  localparam logic [127:0] BX = 128'h00000233857E4E8B5F0055126E7D7B7C;
  localparam logic [127:0] BY = 128'h000019C8C91063EB4276371D68B6B4D9;
  localparam logic [127:0] KC = 128'h00000FD4C926FD178E9805E663021744;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] path_sel = '0;
  logic [108:0] x_in = '0, y_in = '0, inv_in = '0;
  logic busy, done, err;
  logic [108:0] result;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ec_step_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .path_sel(path_sel),
    .x_in(x_in), .y_in(y_in), .inv_in(inv_in),
    .busy(busy), .done(done), .err(err), .result(result)
  );

  function automatic logic [127:0] fadd(logic [127:0] a, logic [127:0] b);
    logic [255:0] w;
    w = ({128'd0, a} + {128'd0, b}) % {128'd0, PM};
    return w[127:0];
  endfunction
  function automatic logic [127:0] fsub(logic [127:0] a, logic [127:0] b);
    logic [255:0] w;
    w = ({128'd0, a} + {128'd0, PM} - {128'd0, b}) % {128'd0, PM};
    return w[127:0];
  endfunction
  function automatic logic [127:0] fmul(logic [127:0] a, logic [127:0] b);
    logic [255:0] w;
    w = ({128'd0, a} * {128'd0, b}) % {128'd0, PM};
    return w[127:0];
  endfunction

  function automatic logic [127:0] model(logic [1:0] sel, logic [127:0] x,
                                         logic [127:0] y, logic [127:0] iv);
    logic [127:0] s, u, v, q, gx, gy;
    if (sel == 2'd3) return '0;
    if (sel == 2'd2) begin
      q = fmul(x, x);
      s = fmul(fadd(fadd(fadd(q, q), q), KC), iv);
      v = fsub(fsub(fmul(s, s), x), x);
    end else begin
      gx = (sel == 2'd1) ? BX : AX;
      gy = (sel == 2'd1) ? BY : AY;
      s = fmul(fsub(gy, y), iv);
      u = fadd(x, gx);
      v = fsub(fmul(s, s), u);
    end
    return fsub(fmul(s, fsub(x, v)), y);
  endfunction

  function automatic logic [127:0] rnd_fe();
    logic [127:0] r;
    r = {$urandom(), $urandom(), $urandom(), $urandom()};
    return r % PM;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8: per-cycle comparison of busy/done against model timing
  task automatic run_case(input logic [1:0] sel, input logic [127:0] x,
                          input logic [127:0] y, input logic [127:0] iv,
                          input bit disturb);
    int lat;
    logic [127:0] exp;
    string tag;
    exp = model(sel, x, y, iv);
    lat = (sel == 2'd3) ? 0 : (sel == 2'd2) ? 4 * 111 + 7 : 3 * 111 + 5;
    tag = (sel == 2'd0) ? "R2" : (sel == 2'd1) ? "R3" : (sel == 2'd2) ? "R4" : "R5";
    @(negedge clk);
    path_sel = sel; x_in = x[108:0]; y_in = y[108:0]; inv_in = iv[108:0];
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= lat + 2; j++) begin
      if (disturb && j == 150) begin
        start = 1'b1; path_sel = sel + 2'd1; x_in = '1; y_in = '0; inv_in = '1;
      end
      if (disturb && j == 156) start = 1'b0;
      chk(busy == (j <= lat + 1), disturb ? "R6 busy" : "R7 busy", 128'(busy),
          128'(j <= lat + 1));
      chk(done == (j == lat + 1), disturb ? "R6 done" : "R7 done", 128'(done),
          128'(j == lat + 1));
      if (j == 1 && lat > 0) chk(result == '0, "R8 cleared", 128'(result), '0);
      if (j == 1) chk(err == (sel == 2'd3), "R8 err set", 128'(err), 128'(sel == 2'd3));
      if (j == lat + 1) begin
        chk(128'(result) == exp, tag, 128'(result), exp);
        chk(128'(result) < PM, "R1 range", 128'(result), PM);
        chk(err == (sel == 2'd3), "R5 err", 128'(err), 128'(sel == 2'd3));
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(128'(result) == exp, "R8 hold", 128'(result), exp);
    chk(!busy && !done, "R8 idle", {126'd0, busy, done}, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] pm1;
    pm1 = PM - 128'd1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && result == '0, "R9 reset",
        {busy, done, err, 125'd0}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && result == '0, "R9 after release",
        {busy, done, err, 125'd0}, '0);
    run_case(2'd0, rnd_fe(), rnd_fe(), rnd_fe(), 1'b0);
    run_case(2'd1, rnd_fe(), rnd_fe(), rnd_fe(), 1'b0);
    run_case(2'd2, rnd_fe(), rnd_fe(), rnd_fe(), 1'b0);
    run_case(2'd0, '0, '0, '0, 1'b0);
    run_case(2'd2, pm1, pm1, pm1, 1'b0);
    run_case(2'd1, pm1, pm1, pm1, 1'b0);
    run_case(2'd3, rnd_fe(), rnd_fe(), rnd_fe(), 1'b0);
    run_case(2'd0, rnd_fe(), rnd_fe(), rnd_fe(), 1'b1);
    run_case(2'd2, rnd_fe(), rnd_fe(), rnd_fe(), 1'b1);
    run_case(2'd1, rnd_fe(), '0, pm1, 1'b0);
    run_case(2'd2, '0, rnd_fe(), rnd_fe(), 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule